// File: doc/BRIEF.md
# Low-Speed Clock Failover Switcher

This block watches an external 32.768 kHz clock pin from a much faster sampling clock and decides whether the chip's switched low-speed clock should come from that pin or from an internal 32 kHz oscillator. When the external clock stops, the block moves the switched clock to the internal oscillator. It moves back only after a run of well-spaced rising edges shows that the external clock has returned. The clock multiplexer itself is represented by two active-low select outputs and an output enable. The block never asserts both selects at once, and it spends one cycle with neither selected whenever the source changes.

A main-power-good input gates every switching decision. While main power is off, the selection is frozen. A control bit then decides whether the internal oscillator keeps running or is gated off. A second control bit picks the source of a downstream reference: either always the external clock, or the switched clock. A third control bit turns automatic failover off and pins the switched clock to the external source. The control bits and a clock-detected status flag are reached through a small word-addressed register port whose writes take effect on the next edge of the sampling clock.

Top module: `lsclk_failover`

## Requirements
- R1: After the synchronous reset the control word reads 0, the status word reads 0, the internal source is selected (`int_sel_n`=0, `ext_sel_n`=1), `clk_out_en` is 1, and `ref_on_ext` is 1.
- R2: Status bit 0 (address 0) becomes 1 once 4 consecutive rising edges arrive on `ext_clk_in`, each within GAP_LIMIT (default 8) sampling cycles of the previous edge. If the external period exceeds GAP_LIMIT sampling cycles, the bit stays 0.
- R3: Status bit 0 returns to 0 when no rising edge has been seen for GAP_LIMIT sampling cycles.
- R4: With main power on and the disable bit at 0, a cleared detect flag causes the internal source to be selected.
- R5: With main power on and the disable bit at 0, a set detect flag causes the external source to be selected again.
- R6: Control bit 0 (address 1) is the switcher disable. When it is 1 and main power is on, the external source is selected whatever the detect flag says.
- R7: While `main_pwr_ok` is 0, the selected source does not change, although the detect flag keeps tracking the pin.
- R8: Control bit 1 is the power-well emulation bit. `int_osc_en` is 0 only when this bit is 1 and `main_pwr_ok` is 0; otherwise it is 1.
- R9: Control bit 2 is the reference select. `ref_on_ext` is 1 when the bit is 0. When the bit is 1, `ref_on_ext` is 1 exactly when the switched clock is on the external source.
- R10: The two selects are never low together. Every change of source passes through at least one cycle with both selects high and `clk_out_en` low.
- R11: Only bits 2:0 of the control word are stored, and its other bits read 0. Status bits 31:1 read 0. Writes to the status address are ignored, and addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset (battery-backed power-on) |
| ext_clk_in | input | 1 | External 32 kHz clock pin, asynchronous |
| main_pwr_ok | input | 1 | Main power good; switching only while 1 |
| bus_addr | input | 2 | Word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_sel_n | output | 1 | Active-low select of the external source |
| int_sel_n | output | 1 | Active-low select of the internal source |
| clk_out_en | output | 1 | Switched clock output enable |
| int_osc_en | output | 1 | Internal oscillator run enable |
| ref_on_ext | output | 1 | Reference taken from the external source |

## Verification
A wrong gap or edge count inside the monitor appears at status bit 0 as an off-by-one in the period at which detection is lost. A period sweep across the GAP_LIMIT boundary exposes it within a few external cycles. A wrong selection state appears at the select outputs two sampling cycles after the detect flag changes. A missed freeze under main-power-off appears as a select change while power is low. A missing break cycle is caught the same cycle by the monitor on the selects.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;

    typedef enum logic [1:0] {
        SRC_EXT    = 2'd0,
        SRC_INT    = 2'd1,
        BRK_TO_EXT = 2'd2,
        BRK_TO_INT = 2'd3
    } src_state_e;

    typedef struct packed {
        logic ref_switched;
        logic int_gate_emul;
        logic sw_disable;
    } ctrl_t;

    function automatic logic want_external(input logic pwr, input logic dis,
                                           input logic det, input logic on_ext);
        if (!pwr) return on_ext;
        if (dis)  return 1'b1;
        return det;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        return {{(REG_W-CTRL_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/lsclk_edge_mon.sv
module lsclk_edge_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_LIMIT   = 8,
    parameter int GOOD_EDGES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    output logic detect
);
    localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
    localparam int GOOD_W = $clog2(GOOD_EDGES + 1);
    localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(GAP_LIMIT);
    localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(GAP_LIMIT - 1);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(GOOD_EDGES);

    logic [SYNC_STAGES:0] sh;
    logic                 rise;
    logic [GAP_W-1:0]     gap_cnt;
    logic [GOOD_W-1:0]    good_cnt;
    logic [GOOD_W-1:0]    good_nxt;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-1:0], ext_in};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

    always_comb begin
        if (gap_cnt == GAP_MAX)       good_nxt = GOOD_W'(1);
        else if (good_cnt == GOOD_MAX) good_nxt = good_cnt;
        else                           good_nxt = good_cnt + GOOD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= '0;
            good_cnt <= '0;
            detect   <= 1'b0;
        end else if (rise) begin
            gap_cnt  <= '0;
            good_cnt <= good_nxt;
            if (good_nxt == GOOD_MAX) detect <= 1'b1;
        end else if (gap_cnt != GAP_MAX) begin
            gap_cnt <= gap_cnt + GAP_W'(1);
            if (gap_cnt == GAP_LAST) begin
                detect   <= 1'b0;
                good_cnt <= '0;
            end
        end
    end

    // R3: a set flag implies the silence window has not expired
    assert_gap_ok_R3: assert property (@(posedge clk) disable iff (rst)
        detect |-> (gap_cnt < GAP_MAX));

    // R2: the flag only rises on a qualified edge
    assert_rise_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(detect) |-> $past(rise));
endmodule

// File: rtl/lsclk_src_fsm.sv
module lsclk_src_fsm
    import lsclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic main_pwr_ok,
    input  logic sw_disable,
    input  logic detect,
    output logic ext_sel_n,
    output logic int_sel_n,
    output logic clk_out_en,
    output logic on_ext
);
    src_state_e state;
    logic       want;

    assign want = want_external(main_pwr_ok, sw_disable, detect, state == SRC_EXT);

    always_ff @(posedge clk) begin
        if (rst) state <= SRC_INT;
        else begin
            case (state)
                SRC_EXT:    if (!want) state <= BRK_TO_INT;
                SRC_INT:    if (want)  state <= BRK_TO_EXT;
                BRK_TO_EXT: state <= SRC_EXT;
                default:    state <= SRC_INT;
            endcase
        end
    end

    assign ext_sel_n  = (state != SRC_EXT);
    assign int_sel_n  = (state != SRC_INT);
    assign clk_out_en = ~ext_sel_n | ~int_sel_n;
    assign on_ext     = (state == SRC_EXT);

    // R10: external only engages after a cycle with internal released
    assert_brk_ext_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_sel_n) |-> $past(int_sel_n));

    // R10: internal only engages after a cycle with external released
    assert_brk_int_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(int_sel_n) |-> $past(ext_sel_n));

    // R7: a settled selection is frozen while main power is off
    assert_pwr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!main_pwr_ok && (state == SRC_EXT || state == SRC_INT)) |=> $stable(state));
endmodule

// File: rtl/lsclk_csr.sv
module lsclk_csr
    import lsclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              detect,
    output ctrl_t             ctrl
);
    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else if (bus_wr && bus_addr == ADDR_CTRL) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        case (bus_addr)
            ADDR_STATUS: bus_rdata = {{(REG_W-1){1'b0}}, detect};
            ADDR_CTRL:   bus_rdata = pack_ctrl(ctrl);
            default:     bus_rdata = '0;
        endcase
    end

    // R11: reserved bits never read as 1
    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:CTRL_W] == '0);
endmodule

// File: rtl/lsclk_failover.sv
module lsclk_failover
    import lsclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_LIMIT   = 8,
    parameter int GOOD_EDGES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk_in,
    input  logic              main_pwr_ok,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              ext_sel_n,
    output logic              int_sel_n,
    output logic              clk_out_en,
    output logic              int_osc_en,
    output logic              ref_on_ext
);
    logic  detect;
    logic  on_ext;
    ctrl_t ctrl;

    lsclk_edge_mon #(
        .SYNC_STAGES(SYNC_STAGES),
        .GAP_LIMIT  (GAP_LIMIT),
        .GOOD_EDGES (GOOD_EDGES)
    ) mon_i (
        .clk    (clk),
        .rst    (rst),
        .ext_in (ext_clk_in),
        .detect (detect)
    );

    lsclk_csr csr_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .detect    (detect),
        .ctrl      (ctrl)
    );

    lsclk_src_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .main_pwr_ok (main_pwr_ok),
        .sw_disable  (ctrl.sw_disable),
        .detect      (detect),
        .ext_sel_n   (ext_sel_n),
        .int_sel_n   (int_sel_n),
        .clk_out_en  (clk_out_en),
        .on_ext      (on_ext)
    );

    assign int_osc_en = main_pwr_ok | ~ctrl.int_gate_emul;
    assign ref_on_ext = ~ctrl.ref_switched | on_ext;

    // R8: oscillator gated whenever power is off under emulation
    assert_osc_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (!main_pwr_ok && ctrl.int_gate_emul) |-> !int_osc_en);
endmodule

// File: tb/lsclk_failover_tb_top.sv
module lsclk_failover_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk_in = 1'b0;
    logic        main_pwr_ok = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_sel_n, int_sel_n, clk_out_en, int_osc_en, ref_on_ext;

    int checks = 0;
    int fails  = 0;
    int overlap_bad = 0;
    int brk_cycles = 0;
    bit done = 1'b0;
    logic prev_ext = 1'b0, prev_int = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsclk_failover dut_i (
        .clk(clk), .rst(rst), .ext_clk_in(ext_clk_in), .main_pwr_ok(main_pwr_ok),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_sel_n(ext_sel_n), .int_sel_n(int_sel_n), .clk_out_en(clk_out_en),
        .int_osc_en(int_osc_en), .ref_on_ext(ref_on_ext)
    );

    // R10 monitor: no overlap, no direct hand-over between sources
    always @(negedge clk) begin
        if (!rst) begin
            if (!ext_sel_n && !int_sel_n) overlap_bad++;
            if ((prev_ext && !int_sel_n) || (prev_int && !ext_sel_n)) overlap_bad++;
            if (!clk_out_en) brk_cycles++;
            prev_ext = !ext_sel_n;
            prev_int = !int_sel_n;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        ext_clk_in = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ext(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            ext_clk_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            ext_clk_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd1, v); check("R1 ctrl", v, 32'h0);
        rd_reg(2'd0, v); check("R1 status", v, 32'h0);
        check("R1 selects", {30'b0, ext_sel_n, int_sel_n}, 32'h2);
        check("R1 en/osc/ref", {29'b0, clk_out_en, int_osc_en, ref_on_ext}, 32'h7);

        // R2/R4/R5 period sweep across the gap limit
        for (int p = 2; p <= 14; p++) begin
            logic good;
            good = (p <= LIMIT);
            idle(20);
            check("R4 int after stop", {31'b0, int_sel_n}, 32'h0);
            run_ext(p, 10);
            rd_reg(2'd0, v);
            check($sformatf("R2 detect p=%0d", p), v, {31'b0, good});
            check($sformatf("R5 select p=%0d", p), {31'b0, ext_sel_n}, {31'b0, !good});
        end

        // R3 loss of clock
        run_ext(6, 8);
        idle(3);
        rd_reg(2'd0, v); check("R3 still set", v, 32'h1);
        idle(20);
        rd_reg(2'd0, v); check("R3 cleared", v, 32'h0);
        check("R4 failover", {30'b0, ext_sel_n, int_sel_n}, 32'h2);

        // R6 disable forces external
        wr_reg(2'd1, 32'h1);
        idle(4);
        check("R6 forced ext", {30'b0, ext_sel_n, int_sel_n}, 32'h1);
        wr_reg(2'd1, 32'h0);
        idle(4);
        check("R6 released", {30'b0, ext_sel_n, int_sel_n}, 32'h2);

        // R7 freeze while power off
        main_pwr_ok = 1'b0;
        run_ext(6, 10);
        rd_reg(2'd0, v); check("R7 detect tracks", v, 32'h1);
        check("R7 held int", {30'b0, ext_sel_n, int_sel_n}, 32'h2);
        main_pwr_ok = 1'b1;
        idle(3);
        check("R5 ext after power", {30'b0, ext_sel_n, int_sel_n}, 32'h1);
        main_pwr_ok = 1'b0;
        idle(20);
        rd_reg(2'd0, v); check("R7 detect lost", v, 32'h0);
        check("R7 held ext", {30'b0, ext_sel_n, int_sel_n}, 32'h1);
        main_pwr_ok = 1'b1;
        idle(4);
        check("R7 released", {30'b0, ext_sel_n, int_sel_n}, 32'h2);

        // R8 oscillator gating table
        for (int e = 0; e < 2; e++) begin
            for (int w = 0; w < 2; w++) begin
                wr_reg(2'd1, e[0] ? 32'h2 : 32'h0);
                main_pwr_ok = w[0];
                @(negedge clk);
                check($sformatf("R8 emul=%0d pwr=%0d", e, w), {31'b0, int_osc_en},
                      {31'b0, (w != 0) || (e == 0)});
            end
        end
        main_pwr_ok = 1'b1;
        idle(4);

        // R9 reference source table
        for (int r = 0; r < 2; r++) begin
            for (int d = 0; d < 2; d++) begin
                wr_reg(2'd1, (r[0] ? 32'h4 : 32'h0) | (d[0] ? 32'h1 : 32'h0));
                idle(4);
                check($sformatf("R9 ref=%0d ext=%0d", r, d), {31'b0, ref_on_ext},
                      {31'b0, (r == 0) || (d != 0)});
            end
        end

        // R11 register map edges
        wr_reg(2'd1, 32'hFFFF_FFF8);
        rd_reg(2'd1, v); check("R11 ctrl reserved", v, 32'h0);
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_reg(2'd1, v); check("R11 ctrl stored", v, 32'h7);
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, v); check("R11 status write ignored", v, 32'h0);
        rd_reg(2'd2, v); check("R11 addr2", v, 32'h0);
        rd_reg(2'd3, v); check("R11 addr3", v, 32'h0);

        // R10 break-before-make summary
        check("R10 overlap", overlap_bad, 0);
        check("R10 break seen", {31'b0, brk_cycles > 0}, 32'h1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule